// File: doc/BRIEF.md
# Multi-Lane Double-Data-Rate Hit Word Serializer

This block sits between a self-triggered strip readout core and its serial output pads. Each hit the core reports has a 3-bit pulse amplitude, a 7-bit channel number and an 8-bit time stamp. The block accepts one hit per acquisition clock cycle. It carries the hit across to an independent readout clock through a 16-entry FIFO with Gray-coded pointers. There the hit is packed into a 24-bit word that ends in a 6-bit boundary marker.

The word is spread over one, two, four or six serial lanes. Each lane carries two bits per readout period: one for the rising half of the period and one for the falling half. The block exposes both of these bits as a registered pair, which models the double-data-rate output register. When no hit is waiting at a word boundary, the block sends an idle word with its own marker. A receiver can therefore keep word alignment on a link that is never silent. If a hit arrives while the FIFO is full, the hit is dropped and a sticky flag is raised.

Top module: `hit_ddr_serializer`

## Requirements
- R1: A data word has the layout bits [23:21] amplitude, [20:14] channel, [13:6] time stamp and [5:0] the data marker 6'b101101. Bit 23 is the first bit of the stream.
- R2: `lane_mode` encodes the lane count N as 0→1, 1→2, 2→4 and 3→6. One word therefore takes 12, 6, 3 or 2 readout cycles, and words follow each other with no gap.
- R3: Number the stream positions p = 0..23, where p is the position of word bit 23−p. In readout cycle c of a word, lane k (k < N) carries position 2Nc+k on `lane_rise[k]` and position 2Nc+N+k on `lane_fall[k]`.
- R4: On lanes k ≥ N, both `lane_rise[k]` and `lane_fall[k]` are 0.
- R5: If the FIFO is empty at a word boundary, the block sends an idle word. Its bits [23:6] are all zero and its marker is 6'b010010.
- R6: `lane_mode` is sampled only in the first cycle of a word. A change in the middle of a word takes effect at the next word boundary.
- R7: Every hit accepted in the acquisition domain is sent exactly once, in arrival order. The FIFO holds 16 hits, and its pointers change by one bit per step when they cross domains.
- R8: A hit that arrives while 16 hits are stored is dropped, and the stored hits are still delivered. `fifo_overflow` rises after the hit is dropped and stays high until the acquisition reset. Storing the 16th hit does not raise it.
- R9: While its domain's reset is low, every lane output is 0 and `fifo_overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_acq | input | 1 | Acquisition clock |
| rst_acq_n | input | 1 | Asynchronous active-low reset, acquisition domain |
| hit_valid | input | 1 | A hit is presented this cycle |
| hit_amp | input | 3 | Pulse amplitude |
| hit_chan | input | 7 | Channel number |
| hit_ts | input | 8 | Time stamp |
| fifo_overflow | output | 1 | Sticky flag: at least one hit was dropped |
| clk_ro | input | 1 | Readout clock, asynchronous to clk_acq |
| rst_ro_n | input | 1 | Asynchronous active-low reset, readout domain |
| lane_mode | input | 2 | Active lane count selector (R2 encoding) |
| lane_rise | output | 6 | Bit per lane for the rising half of the period |
| lane_fall | output | 6 | Bit per lane for the falling half of the period |

## Verification
The risky coincidences are a word boundary that meets a lane-mode change, and a write into a full FIFO that meets the draining of the FIFO.

- **Mode change against word boundary.** The bench changes `lane_mode` at negative edges whose phase is unrelated to the word phase, and it also toggles the mode for a few cycles in the middle of a run. The bench receiver picks up the mode only at the start of each word and rebuilds every word from that mode. Any early or late switch therefore shows up as a broken marker or a wrong field.
- **Full FIFO against draining.** The FIFO is filled past 16 entries while the readout side is held in reset, and then the readout side is released. The bench checks that exactly the first 16 hits come out in order, that the dropped hits never appear, and that the flag stays high through the drain.

// File: rtl/hws_pkg.sv
`timescale 1ns/1ps
package hws_pkg;
    localparam int AMP_W     = 3;
    localparam int CHAN_W    = 7;
    localparam int TS_W      = 8;
    localparam int MARK_W    = 6;
    localparam int HIT_W     = AMP_W + CHAN_W + TS_W;
    localparam int WORD_W    = HIT_W + MARK_W;
    localparam int MAX_LANES = 6;
    localparam int BEAT_W    = $clog2(WORD_W / 2);

    localparam logic [MARK_W-1:0] MARK_DATA = 6'b101101;
    localparam logic [MARK_W-1:0] MARK_IDLE = 6'b010010;

    typedef enum logic [1:0] {
        LM_ONE  = 2'd0,
        LM_TWO  = 2'd1,
        LM_FOUR = 2'd2,
        LM_SIX  = 2'd3
    } lane_mode_e;

    function automatic logic [2:0] lane_count(input logic [1:0] m);
        case (m)
            LM_ONE:  return 3'd1;
            LM_TWO:  return 3'd2;
            LM_FOUR: return 3'd4;
            default: return 3'd6;
        endcase
    endfunction

    function automatic logic [MAX_LANES-1:0] lane_mask(input logic [1:0] m);
        case (m)
            LM_ONE:  return 6'b000001;
            LM_TWO:  return 6'b000011;
            LM_FOUR: return 6'b001111;
            default: return 6'b111111;
        endcase
    endfunction

    function automatic logic [BEAT_W-1:0] last_beat(input logic [1:0] m);
        case (m)
            LM_ONE:  return BEAT_W'(WORD_W / 2 - 1);
            LM_TWO:  return BEAT_W'(WORD_W / 4 - 1);
            LM_FOUR: return BEAT_W'(WORD_W / 8 - 1);
            default: return BEAT_W'(WORD_W / 12 - 1);
        endcase
    endfunction
endpackage

// File: rtl/hws_sync2.sv
`timescale 1ns/1ps
module hws_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] held;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta = d;
        s_d.held = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.held;
endmodule

// File: rtl/hws_gray_fifo.sv
`timescale 1ns/1ps
module hws_gray_fifo #(
    parameter int DW = 18,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic          ovf,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rd_en,
    output logic [DW-1:0] rdata,
    output logic          empty
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          ovf;
    } wside_t;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } rside_t;

    wside_t w_d, w_q;
    rside_t r_d, r_q;
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rgray_s, wgray_s, wbin_s;
    logic          full, push, pop;

    // write domain
    hws_sync2 #(.W(PW)) u_rsync (.clk(wclk), .rst_n(wrst_n), .d(r_q.gray), .q(rgray_s));

    always_comb begin
        full     = (w_q.gray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
        push     = wr_en && !full;
        w_d.bin  = w_q.bin + PW'(push);
        w_d.gray = w_d.bin ^ (w_d.bin >> 1);
        w_d.ovf  = w_q.ovf || (wr_en && full);
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) w_q <= '0;
        else         w_q <= w_d;
    end

    always_ff @(posedge wclk) begin
        if (push) mem[w_q.bin[AW-1:0]] <= wdata;
    end

    assign ovf = w_q.ovf;

    // read domain
    hws_sync2 #(.W(PW)) u_wsync (.clk(rclk), .rst_n(rrst_n), .d(w_q.gray), .q(wgray_s));

    always_comb begin
        empty    = (r_q.gray == wgray_s);
        pop      = rd_en && !empty;
        r_d.bin  = r_q.bin + PW'(pop);
        r_d.gray = r_d.bin ^ (r_d.bin >> 1);
        for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) r_q <= '0;
        else         r_q <= r_d;
    end

    assign rdata = mem[r_q.bin[AW-1:0]];

    AST_WGRAY_ONE_BIT: assert property (@(posedge wclk) disable iff (!wrst_n)
        $countones(w_q.gray ^ $past(w_q.gray)) <= 1); // R7
    AST_RGRAY_ONE_BIT: assert property (@(posedge rclk) disable iff (!rrst_n)
        $countones(r_q.gray ^ $past(r_q.gray)) <= 1); // R7
    AST_OCCUPANCY_BOUND: assert property (@(posedge rclk) disable iff (!rrst_n)
        (wbin_s - r_q.bin) <= PW'(DEPTH)); // R7
    AST_OVF_STICKY: assert property (@(posedge wclk) disable iff (!wrst_n)
        w_q.ovf |=> w_q.ovf); // R8
endmodule

// File: rtl/hws_lane_shifter.sv
`timescale 1ns/1ps
module hws_lane_shifter
    import hws_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           lane_mode,
    input  logic                 fifo_empty,
    input  logic [HIT_W-1:0]     fifo_data,
    output logic                 pop,
    output logic [MAX_LANES-1:0] lane_rise,
    output logic [MAX_LANES-1:0] lane_fall
);
    typedef struct packed {
        logic [WORD_W-1:0]    sh;
        logic [BEAT_W-1:0]    beat;
        logic [1:0]           mode;
        logic [MAX_LANES-1:0] rise;
        logic [MAX_LANES-1:0] fall;
    } shift_t;

    shift_t s_d, s_q;
    logic                 boundary;
    logic [1:0]           mode_eff;
    logic [WORD_W-1:0]    cur_word;
    logic [MAX_LANES-1:0] en_mask, rise_nx, fall_nx;

    // choose the word and the lane setting that apply this cycle
    always_comb begin
        boundary = (s_q.beat == '0);
        mode_eff = boundary ? lane_mode : s_q.mode;
        pop      = boundary && !fifo_empty;
        if (!boundary)      cur_word = s_q.sh;
        else if (fifo_empty) cur_word = {{HIT_W{1'b0}}, MARK_IDLE};
        else                cur_word = {fifo_data, MARK_DATA};
        en_mask  = lane_mask(mode_eff);
    end

    // lane k takes the k-th remaining bit on the rise, and bit k + N on the fall
    for (genvar k = 0; k < MAX_LANES; k++) begin : g_lane
        assign rise_nx[k] = en_mask[k] & cur_word[WORD_W-1-k];
        assign fall_nx[k] = en_mask[k] &
            ((mode_eff == LM_ONE)  ? cur_word[WORD_W-2-k] :
             (mode_eff == LM_TWO)  ? cur_word[WORD_W-3-k] :
             (mode_eff == LM_FOUR) ? cur_word[WORD_W-5-k] :
                                     cur_word[WORD_W-7-k]);
    end

    always_comb begin
        s_d      = s_q;
        s_d.mode = mode_eff;
        s_d.sh   = cur_word << {lane_count(mode_eff), 1'b0};
        s_d.beat = boundary ? last_beat(mode_eff) : s_q.beat - BEAT_W'(1);
        s_d.rise = rise_nx;
        s_d.fall = fall_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lane_rise = s_q.rise;
    assign lane_fall = s_q.fall;

    AST_IDLE_LANES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.rise | s_q.fall) & ~lane_mask(s_q.mode)) == '0); // R4
    AST_BEAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.beat <= last_beat(s_q.mode)); // R2
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.beat != '0) |=> $stable(s_q.mode)); // R6
endmodule

// File: rtl/hit_ddr_serializer.sv
`timescale 1ns/1ps
module hit_ddr_serializer
    import hws_pkg::*;
#(
    parameter int FIFO_AW = 4
) (
    input  logic                 clk_acq,
    input  logic                 rst_acq_n,
    input  logic                 hit_valid,
    input  logic [AMP_W-1:0]     hit_amp,
    input  logic [CHAN_W-1:0]    hit_chan,
    input  logic [TS_W-1:0]      hit_ts,
    output logic                 fifo_overflow,
    input  logic                 clk_ro,
    input  logic                 rst_ro_n,
    input  logic [1:0]           lane_mode,
    output logic [MAX_LANES-1:0] lane_rise,
    output logic [MAX_LANES-1:0] lane_fall
);
    logic [HIT_W-1:0] fifo_q;
    logic             fifo_empty, fifo_pop;

    hws_gray_fifo #(.DW(HIT_W), .AW(FIFO_AW)) u_fifo (
        .wclk   (clk_acq),
        .wrst_n (rst_acq_n),
        .wr_en  (hit_valid),
        .wdata  ({hit_amp, hit_chan, hit_ts}),
        .ovf    (fifo_overflow),
        .rclk   (clk_ro),
        .rrst_n (rst_ro_n),
        .rd_en  (fifo_pop),
        .rdata  (fifo_q),
        .empty  (fifo_empty)
    );

    hws_lane_shifter u_shift (
        .clk        (clk_ro),
        .rst_n      (rst_ro_n),
        .lane_mode  (lane_mode),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_q),
        .pop        (fifo_pop),
        .lane_rise  (lane_rise),
        .lane_fall  (lane_fall)
    );
endmodule

// File: tb/sim_hit_ddr_serializer.sv
`timescale 1ns/1ps
module sim_hit_ddr_serializer;
    logic       clk_acq = 1'b0, clk_ro = 1'b0;
    logic       rst_acq_n = 1'b0, rst_ro_n = 1'b0;
    logic       hit_valid = 1'b0;
    logic [2:0] hit_amp = '0;
    logic [6:0] hit_chan = '0;
    logic [7:0] hit_ts = '0;
    logic [1:0] lane_mode = '0;
    logic       fifo_overflow;
    logic [5:0] lane_rise, lane_fall;

    int checks = 0;
    int errors = 0;
    int idle_seen = 0;
    logic [23:0] expq[$];

    hit_ddr_serializer u0 (
        .clk_acq(clk_acq), .rst_acq_n(rst_acq_n), .hit_valid(hit_valid),
        .hit_amp(hit_amp), .hit_chan(hit_chan), .hit_ts(hit_ts),
        .fifo_overflow(fifo_overflow), .clk_ro(clk_ro), .rst_ro_n(rst_ro_n),
        .lane_mode(lane_mode), .lane_rise(lane_rise), .lane_fall(lane_fall)
    );

    always #2   clk_ro  = ~clk_ro;   // 250 MHz
    always #3.5 clk_acq = ~clk_acq;

    function automatic int n_of(input logic [1:0] m);
        case (m)
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 4;
            default: return 6;
        endcase
    endfunction

    task automatic fail(input string what, input logic [23:0] act, input logic [23:0] exp);
        errors++;
        $display("FAIL %s: got %h expected %h", what, act, exp);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // receiver: rebuilds words from the lane pairs using the mode at each word start
    logic        rx_active = 1'b0;
    int          rx_beat = 0;
    logic [1:0]  mode_cap = '0;
    logic [23:0] rx_word = '0;
    bit          stray = 0;

    always @(posedge clk_ro) begin
        rx_active = rst_ro_n;
        if (!rst_ro_n) begin
            rx_beat = 0;
            stray   = 0;
        end
        if (rx_beat == 0) mode_cap = lane_mode;   // R6: mode applies from word start
    end

    task automatic judge_word(input logic [23:0] w, input bit bad_lane);
        logic [23:0] e;
        checks++;
        if (bad_lane) fail("R4 inactive lane high", w, 24'h0);
        checks++;
        if (w[5:0] == 6'b010010) begin
            if (w[23:6] != '0) fail("R5 idle word body", w, {18'h0, 6'b010010});
            else idle_seen++;
        end else if (w[5:0] == 6'b101101) begin
            if (expq.size() == 0) fail("R7 unexpected data word", w, 24'h0);
            else begin
                e = expq.pop_front();
                if (w != e) fail("R1 R3 R6 data word", w, e);
            end
        end else begin
            fail("R2 R3 R6 framing lost", w, {18'h0, 6'b101101});
        end
    endtask

    always @(negedge clk_ro) begin
        int n;
        if (rx_active) begin
            n = n_of(mode_cap);
            if (rx_beat == 0) rx_word = '0;
            for (int k = 0; k < 6; k++) begin
                if (k < n) begin
                    rx_word[23 - (2*n*rx_beat + k)]     = lane_rise[k];
                    rx_word[23 - (2*n*rx_beat + n + k)] = lane_fall[k];
                end else if (lane_rise[k] || lane_fall[k]) begin
                    stray = 1;
                end
            end
            rx_beat++;
            if (rx_beat == 12 / n) begin
                rx_beat = 0;
                judge_word(rx_word, stray);
                stray = 0;
            end
        end
    end

    task automatic push_hit(input logic [2:0] a, input logic [6:0] c,
                            input logic [7:0] t, input bit keep);
        @(negedge clk_acq);
        hit_valid = 1'b1; hit_amp = a; hit_chan = c; hit_ts = t;
        if (keep) expq.push_back({a, c, t, 6'b101101});
        @(negedge clk_acq);
        hit_valid = 1'b0;
    endtask

    task automatic drain(input string tag);
        int t = 0;
        while (expq.size() != 0 && t < 4000) begin
            @(negedge clk_ro);
            t++;
        end
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R7 %s: %0d words still missing, expected 0", tag, expq.size());
        end
    endtask

    task automatic check_bit(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic check_lanes_zero(input string what);
        checks++;
        if (lane_rise !== 6'h0 || lane_fall !== 6'h0)
            fail(what, {12'h0, lane_rise, lane_fall}, 24'h0);
    endtask

    task automatic run_mode(input int m);
        logic [2:0] a;
        logic [6:0] c;
        logic [7:0] t;
        @(negedge clk_ro);
        lane_mode = 2'(m);
        for (int i = 0; i < 24; i++) begin
            a = 3'(i);
            c = 7'((i * 37 + m * 11) % 128);
            t = 8'((i * 73 + m * 29) % 256);
            if (i == 0) begin a = 3'd0; c = 7'd0;   t = 8'd0;   end   // R1 all-zero data hit
            if (i == 1) begin a = 3'd7; c = 7'd127; t = 8'd255; end   // R1 extreme fields
            push_hit(a, c, t, 1);
            repeat (9) @(negedge clk_acq);
            if (i == 9) begin                                           // R6 mid-stream toggle
                @(negedge clk_ro);
                lane_mode = 2'(m) ^ 2'd1;
                repeat (3) @(negedge clk_ro);
                lane_mode = 2'(m);
            end
        end
        drain($sformatf("mode %0d", m));
        check_bit("R8 no overflow at low rate", fifo_overflow, 1'b0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL R7 watchdog: run did not complete, expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (6) @(negedge clk_ro);
        check_lanes_zero("R9 lanes in reset");
        check_bit("R9 overflow in reset", fifo_overflow, 1'b0);

        @(negedge clk_acq) rst_acq_n = 1'b1;
        @(negedge clk_ro)  rst_ro_n  = 1'b1;
        repeat (40) @(negedge clk_ro);
        checks++;
        if (idle_seen < 2) begin
            errors++;
            $display("FAIL R5 idle words: got %0d expected at least 2", idle_seen);
        end

        for (int m = 0; m < 4; m++) run_mode(m);   // R2 R3 all lane counts

        // R8: fill with readout held in reset
        @(negedge clk_ro)  rst_ro_n  = 1'b0;
        @(negedge clk_acq) rst_acq_n = 1'b0;
        repeat (3) @(negedge clk_acq);
        rst_acq_n = 1'b1;
        expq.delete();
        for (int i = 0; i < 16; i++)
            push_hit(3'(i), 7'(i * 8 + 3), 8'(255 - i * 16), 1);
        repeat (4) @(negedge clk_acq);
        check_bit("R8 sixteen stored, no overflow", fifo_overflow, 1'b0);
        push_hit(3'd5, 7'd99, 8'hAA, 0);
        push_hit(3'd6, 7'd98, 8'h55, 0);
        repeat (2) @(negedge clk_acq);
        check_bit("R8 overflow raised", fifo_overflow, 1'b1);
        check_lanes_zero("R9 lanes while readout in reset");
        @(negedge clk_ro);
        lane_mode = 2'd3;
        rst_ro_n  = 1'b1;
        drain("after overflow");
        repeat (20) @(negedge clk_ro);
        check_bit("R8 overflow sticky", fifo_overflow, 1'b1);

        @(negedge clk_ro)  rst_ro_n  = 1'b0;
        @(negedge clk_acq) rst_acq_n = 1'b0;
        repeat (2) @(negedge clk_acq);
        check_bit("R9 overflow cleared by reset", fifo_overflow, 1'b0);
        rst_acq_n = 1'b1;
        @(negedge clk_ro);
        lane_mode = 2'd2;
        rst_ro_n  = 1'b1;
        for (int i = 0; i < 5; i++) begin
            push_hit(3'(7 - i), 7'(i * 25), 8'(i * 50), 1);
            repeat (3) @(negedge clk_acq);
        end
        drain("after reset");
        repeat (10) @(negedge clk_ro);

        summary();
        $finish;
    end
endmodule